// File: doc/BRIEF.md
# SPI Flash Fast-Read Target

This block behaves like the read side of a serial flash device on an SPI bus. It watches the chip-select, serial clock and serial input lines. When a transfer opens with the fast-read command, it takes in a start address and then waits through one dummy byte. After that it sends bytes from an internal byte array, one after another, for as long as chip-select stays low. The serial output comes as a data bit plus an output-enable, so the pad can be tri-stated.

All SPI lines are sampled with a system clock that runs well above the serial clock. Each line goes through a two-stage synchronizer, and clock edges are found in the system-clock domain. The byte array holds 2^ADDR_BITS bytes. A parallel write port loads it before any transfer. Address bits above the array size are dropped, so the read pointer wraps from the top byte back to byte zero.

Top module: `spi_fast_read_target`

## Requirements
- R1: After reset, and while chip-select is high, so_oe_o is 0 and so_o is 0.
- R2: The first 8 bits after chip-select falls form the command, sampled MSB first on rising serial-clock edges. Value 0x0B starts a fast read.
- R3: The next 24 bits form the start address, MSB first. Only the low ADDR_BITS bits select the byte, and higher bits are ignored.
- R4: The 8 bits after the address are a dummy byte, and their values have no effect. so_oe_o stays 0 through the command, address and dummy bits.
- R5: Data bits change only on falling serial-clock edges. The first one appears on the falling edge after the 40th rising edge. Each byte is sent MSB first, starting at the captured address, and so_oe_o is 1 while data is sent.
- R6: After each byte the read address goes up by one, and output continues without limit while chip-select stays low.
- R7: The byte after address 2^ADDR_BITS-1 comes from address 0.
- R8: Chip-select going high ends the transfer at any point and releases so_oe_o. The next transfer starts again with a command byte.
- R9: Transfers work in SPI mode 0 (clock idle low) and in mode 3 (clock idle high when chip-select falls), with identical data.
- R10: Any command other than 0x0B makes the block ignore the rest of the transfer. so_oe_o stays 0 until chip-select rises.
- R11: A write on the parallel port (wr_en_i high for one clock) stores wr_data_i at wr_addr_i, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the SPI lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | SPI chip-select, active low |
| sck_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI serial data in |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for so_o (0 = high impedance) |
| wr_en_i | input | 1 | Array preload write strobe |
| wr_addr_i | input | ADDR_BITS | Array preload address |
| wr_data_i | input | 8 | Array preload data |

## Verification
The bench starts a read two bytes below the top of the array. A pointer that saturates would repeat the last byte, and one that fails to wrap would read past the end; the scoreboard catches either. A start address with its high bits set would select the wrong byte if those bits leaked into the pointer. Mode 3 and a 0xFF dummy byte check two things: that the first falling edge does not shift a bit out of place, and that the dummy value does not change the address. A transfer cut off in the middle of a byte, followed by a fresh read, and a transfer with an unknown command, check that the output goes high impedance and that no leftover state corrupts the next command.

// File: rtl/spi_frd_pkg.sv
package spi_frd_pkg;
  localparam int unsigned OP_LEN    = 8;
  localparam int unsigned ADDR_LEN  = 24;
  localparam int unsigned DUMMY_LEN = 8;
  localparam logic [7:0]  FAST_READ_OP = 8'h0B;

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DUMMY = 3'd2,
    ST_DATA  = 3'd3,
    ST_SKIP  = 3'd4
  } frd_state_e;
endpackage

// File: rtl/spi_frd_sync.sv
module spi_frd_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frd_mem.sv
module spi_frd_mem #(
  parameter int unsigned ADDR_BITS = 8,
  localparam int unsigned DEPTH    = 1 << ADDR_BITS
) (
  input  logic                 clk_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_BITS-1:0] wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic [ADDR_BITS-1:0] rd_addr_i,
  output logic [7:0]           rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/spi_frd_ctrl.sv
module spi_frd_ctrl
  import spi_frd_pkg::*;
#(
  parameter int unsigned ADDR_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_n_i,
  input  logic                 sck_i,
  input  logic                 si_i,
  input  logic [7:0]           rd_data_i,
  output logic [ADDR_BITS-1:0] rd_addr_o,
  output logic                 so_o,
  output logic                 so_oe_o,
  output logic                 sck_fall_o,
  output logic                 byte_load_o,
  output frd_state_e           state_o
);
  localparam int unsigned CW = $clog2(ADDR_LEN);
  localparam logic [CW-1:0] OP_LAST    = CW'(OP_LEN - 1);
  localparam logic [CW-1:0] ADDR_LAST  = CW'(ADDR_LEN - 1);
  localparam logic [CW-1:0] DUMMY_LAST = CW'(DUMMY_LEN - 1);
  localparam logic [ADDR_BITS-1:0] TOP = {ADDR_BITS{1'b1}};

  frd_state_e           state_q;
  logic [CW-1:0]        cnt_q;
  logic [7:0]           op_q;
  logic [ADDR_BITS-1:0] ptr_q;
  logic [7:0]           out_q;
  logic [2:0]           bit_q;
  logic                 sck_q;
  logic                 so_q, oe_q;
  logic                 rise, fall, load;
  logic [7:0]           op_next;

  assign rise    = sck_i & ~sck_q & ~cs_n_i;
  assign fall    = ~sck_i & sck_q & ~cs_n_i;
  assign load    = fall && (state_q == ST_DATA) && (bit_q == 3'd0);
  assign op_next = {op_q[6:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      op_q    <= '0;
      ptr_q   <= '0;
      out_q   <= '0;
      bit_q   <= '0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else if (cs_n_i) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      bit_q   <= '0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else if (rise) begin
      unique case (state_q)
        ST_CMD: begin
          op_q <= op_next;
          if (cnt_q == OP_LAST) begin
            cnt_q   <= '0;
            state_q <= (op_next == FAST_READ_OP) ? ST_ADDR : ST_SKIP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          ptr_q <= {ptr_q[ADDR_BITS-2:0], si_i};
          if (cnt_q == ADDR_LAST) begin
            cnt_q   <= '0;
            state_q <= ST_DUMMY;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DUMMY: begin
          if (cnt_q == DUMMY_LAST) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (fall && state_q == ST_DATA) begin
      oe_q  <= 1'b1;
      bit_q <= bit_q + 1'b1;
      if (load) begin
        so_q  <= rd_data_i[7];
        out_q <= {rd_data_i[6:0], 1'b0};
        ptr_q <= (ptr_q == TOP) ? '0 : ptr_q + 1'b1;
      end else begin
        so_q  <= out_q[7];
        out_q <= {out_q[6:0], 1'b0};
      end
    end
  end

  assign rd_addr_o   = ptr_q;
  assign so_o        = so_q;
  assign so_oe_o     = oe_q;
  assign sck_fall_o  = fall;
  assign byte_load_o = load;
  assign state_o     = state_q;
endmodule

// File: rtl/spi_fast_read_target.sv
module spi_fast_read_target
  import spi_frd_pkg::*;
#(
  parameter int unsigned ADDR_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_n_i,
  input  logic                 sck_i,
  input  logic                 si_i,
  output logic                 so_o,
  output logic                 so_oe_o,
  input  logic                 wr_en_i,
  input  logic [ADDR_BITS-1:0] wr_addr_i,
  input  logic [7:0]           wr_data_i
);
  logic [2:0]           lines_s;
  logic                 cs_n_s, sck_s, si_s;
  logic [ADDR_BITS-1:0] rd_addr;
  logic [7:0]           rd_data;
  logic                 sck_fall, byte_load;
  frd_state_e           state;

  spi_frd_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_n_i, sck_i, si_i}),
    .q_o    (lines_s)
  );

  assign {cs_n_s, sck_s, si_s} = lines_s;

  spi_frd_mem #(.ADDR_BITS(ADDR_BITS)) i_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  spi_frd_ctrl #(.ADDR_BITS(ADDR_BITS)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_i      (cs_n_s),
    .sck_i       (sck_s),
    .si_i        (si_s),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .so_o        (so_o),
    .so_oe_o     (so_oe_o),
    .sck_fall_o  (sck_fall),
    .byte_load_o (byte_load),
    .state_o     (state)
  );
endmodule

// File: rtl/spi_frd_chk.sv
module spi_frd_chk
  import spi_frd_pkg::*;
#(
  parameter int unsigned ADDR_BITS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_n_s,
  input logic                 sck_fall,
  input logic                 byte_load,
  input logic [ADDR_BITS-1:0] rd_addr,
  input logic                 so_o,
  input logic                 so_oe_o,
  input frd_state_e           state
);
  localparam int unsigned AW = ADDR_BITS;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  AST_DESEL_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> !so_oe_o); // R8

  AST_OE_ONLY_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> state == ST_DATA); // R4

  AST_SO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_fall && !cs_n_s) |=> $stable(so_o)); // R5

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_load && rd_addr != TOP) |=> rd_addr == $past(rd_addr) + AW'(1)); // R6

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_load && rd_addr == TOP) |=> rd_addr == '0); // R7

  AST_SKIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SKIP && !cs_n_s) |=> state == ST_SKIP); // R10
endmodule

bind spi_fast_read_target spi_frd_chk #(.ADDR_BITS(ADDR_BITS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_n_s    (cs_n_s),
  .sck_fall  (sck_fall),
  .byte_load (byte_load),
  .rd_addr   (rd_addr),
  .so_o      (so_o),
  .so_oe_o   (so_oe_o),
  .state     (state)
);

// File: tb/test_spi_fast_read_target.sv
module test_spi_fast_read_target;
  localparam int AB = 8;
  localparam int MB = 1 << AB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sck = 1'b0;
  logic          si = 1'b0;
  logic          wr_en = 1'b0;
  logic [AB-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          so, so_oe;

  int         total = 0;
  int         bad = 0;
  logic [7:0] ref_mem [MB];
  logic [7:0] exp_q [$];
  bit         mon_on = 1'b0;
  int         mon_cnt = 0;
  logic [7:0] mon_byte = '0;
  logic [7:0] exp_b;
  string      cur_req = "R5";

  always #10 clk = ~clk;

  spi_fast_read_target #(.ADDR_BITS(AB)) i_spi_fast_read_target (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cs_n_i    (cs_n),
    .sck_i     (sck),
    .si_i      (si),
    .so_o      (so),
    .so_oe_o   (so_oe),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: assembles bytes at target's sampling edge and compares
  always @(posedge sck) begin
    if (mon_on) begin
      if (!so_oe) chk(1'b0, "R5", "so_oe during data", 0, 1);
      mon_byte = {mon_byte[6:0], so};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected byte", mon_byte, 0);
        else begin
          exp_b = exp_q.pop_front();
          chk(mon_byte == exp_b, cur_req, "data byte", mon_byte, exp_b);
        end
      end
    end
  end

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, inout bit hz);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = b[i]; half();
      if (so_oe) hz = 1'b0;
      sck = 1'b1; half();
    end
  endtask

  task automatic start_xfer(input bit mode3);
    sck = mode3; half();
    cs_n = 1'b0; half();
    mon_cnt = 0;
  endtask

  task automatic end_xfer(input bit mode3);
    if (!mode3) begin sck = 1'b0; half(); end
    cs_n = 1'b1; half(); half();
  endtask

  // driver: pushes expected bytes, then runs the transfer
  task automatic fast_read(input bit mode3, input logic [7:0] op, input logic [23:0] addr,
                           input logic [7:0] dummy, input int nbits, input string req);
    bit hz = 1'b1;
    cur_req = req;
    for (int i = 0; i < nbits / 8; i++)
      exp_q.push_back(ref_mem[(int'(addr[AB-1:0]) + i) % MB]);
    start_xfer(mode3);
    send_byte(op, hz);
    send_byte(addr[23:16], hz);
    send_byte(addr[15:8], hz);
    send_byte(addr[7:0], hz);
    send_byte(dummy, hz);
    chk(hz, "R4", "so hi-z during command phases", !hz, 0);
    mon_on = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0; si = i[0]; half();
      sck = 1'b1; half();
    end
    mon_on = 1'b0;
    end_xfer(mode3);
    chk(exp_q.size() == 0, req, "bytes left in queue", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AB'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    ref_mem[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit hz;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!so_oe, "R1", "so_oe after reset", so_oe, 0);
    chk(!so, "R1", "so after reset", so, 0);

    for (int a = 0; a < MB; a++) wr(a, 8'((a * 37 + 11) ^ (a >> 2)));

    // R2 R3 R5 R6: mode 0 read
    fast_read(1'b0, 8'h0B, 24'h000010, 8'h00, 6 * 8, "R6");
    chk(!so_oe, "R1", "so_oe while deselected", so_oe, 0);

    // R9: mode 3, dummy value 0xFF ignored (R4)
    fast_read(1'b1, 8'h0B, 24'h000040, 8'hFF, 4 * 8, "R9");

    // R7: wrap from top to zero
    fast_read(1'b0, 8'h0B, 24'(MB - 2), 8'h5A, 6 * 8, "R7");
    fast_read(1'b1, 8'h0B, 24'(MB - 1), 8'h00, 3 * 8, "R7");

    // R3: high address bits ignored
    fast_read(1'b0, 8'h0B, 24'hABCD21, 8'h00, 3 * 8, "R3");

    // R8: abort mid-byte, then fresh read
    fast_read(1'b0, 8'h0B, 24'h000080, 8'h00, 2 * 8 + 3, "R8");
    chk(!so_oe, "R8", "so_oe after abort", so_oe, 0);
    fast_read(1'b0, 8'h0B, 24'h000033, 8'h00, 2 * 8, "R8");

    // R10: unknown command keeps SO released
    hz = 1'b1;
    start_xfer(1'b0);
    send_byte(8'h03, hz);
    for (int i = 0; i < 6; i++) send_byte(8'hFF, hz);
    end_xfer(1'b0);
    chk(hz, "R10", "so_oe after unknown command", !hz, 0);
    fast_read(1'b0, 8'h0B, 24'h000005, 8'h00, 2 * 8, "R10");

    // R11: preload port overwrite
    wr(8'h90, 8'hC3);
    wr(8'h91, 8'h3C);
    fast_read(1'b1, 8'h0B, 24'h00008F, 8'h00, 3 * 8, "R11");

    // R2: long stream across many bytes
    fast_read(1'b0, 8'h0B, 24'h0000F0, 8'h00, 20 * 8, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule